// File: doc/BRIEF.md
# Opcode-Decoded ALU with Status Flags

This block is the combinational execute stage of a small 32-bit two's-complement processor. A 5-bit opcode selects one of ten register-register operations (four shifts, four logic functions, add, subtract) or one of three immediate forms (load, AND, add). The block returns the result, a write strobe for the destination register and the four condition flags: negative, zero, carry and signed overflow.

Operand fetch, register write-back, memory, I/O and branching belong to neighbouring blocks. The block sees the destination register index only to suppress writes to register 0. That register always reads as zero, but an operation aimed at it still updates the flags, so software can use it as a compare target. Any opcode the block does not execute leaves every output low.

Top module: `alu_opdec`

## Requirements
- R1: Opcodes 10000, 10001, 10010 and 10011 perform logical shift left, rotate left, logical shift right and arithmetic shift right of operand A by the low 5 bits of operand B. C holds the last bit shifted out, or 0 for an amount of zero; for a rotate that bit is result bit 0. V is 0.
- R2: Opcodes 10100 (one's complement of A), 10111 (AND), 11000 (OR) and 11001 (XOR) produce the bitwise result with C and V cleared.
- R3: Opcode 10101 returns A+B modulo 2^32. C is the carry out of bit 31. V is set when A and B have the same sign and the sum's sign differs from it.
- R4: Opcode 10110 returns A-B modulo 2^32. C is 1 when no borrow occurs (A >= B unsigned). V is set when A and B differ in sign and the result's sign differs from A.
- R5: Opcode 00010 ANDs A with the 20-bit immediate zero-extended, with C and V cleared. Opcode 00011 adds the 20-bit immediate sign-extended to A, with C and V as in R3. Opcode 00001 returns the zero-extended immediate with a register write but no flag update (flag_upd 0, all flags 0).
- R6: Whenever flag_upd is 1, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R7: Any other opcode (00000, 00100 to 01111, 11010 to 11111) gives result 0, wr_en 0, flag_upd 0 and all flags 0.
- R8: When the destination index is 0, wr_en is 0, while result, flag_upd and the flags are unchanged from those for a non-zero destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| dst_sel | input | 3 | Destination register index |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand / shift amount |
| imm | input | 20 | Immediate field |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write strobe |
| flag_upd | output | 1 | Status flags are to be latched |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow / last shifted-out bit |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The interesting overlap is a flag-producing operation aimed at register 0. In the same evaluation the block must update the flags and also hold back the register write. Vectors for add and subtract with destination 0 are applied, and the flags are compared against values worked out by hand for a non-zero destination while wr_en must stay low. A second overlap is a shift whose amount has upper bits set. It is provoked by operand B values such as 0x24 and 0x20, and the result and carry are judged against the masked amount.

// File: rtl/alu_opdec.sv
module alu_opdec #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 20,
  parameter int SEL_W = 3,
  parameter int OP_W  = 5
) (
  input  logic [OP_W-1:0]  op,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             flag_upd,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int SH_W = $clog2(WIDTH);
  localparam int MSB  = WIDTH - 1;

  localparam logic [OP_W-1:0] OP_LDI  = 5'b00001;
  localparam logic [OP_W-1:0] OP_ANDI = 5'b00010;
  localparam logic [OP_W-1:0] OP_ADDI = 5'b00011;
  localparam logic [OP_W-1:0] OP_SHL  = 5'b10000;
  localparam logic [OP_W-1:0] OP_ROL  = 5'b10001;
  localparam logic [OP_W-1:0] OP_SHR  = 5'b10010;
  localparam logic [OP_W-1:0] OP_SAR  = 5'b10011;
  localparam logic [OP_W-1:0] OP_INV  = 5'b10100;
  localparam logic [OP_W-1:0] OP_ADD  = 5'b10101;
  localparam logic [OP_W-1:0] OP_SUB  = 5'b10110;
  localparam logic [OP_W-1:0] OP_AND  = 5'b10111;
  localparam logic [OP_W-1:0] OP_OR   = 5'b11000;
  localparam logic [OP_W-1:0] OP_XOR  = 5'b11001;

  logic [SH_W-1:0]    amt;
  logic [WIDTH-1:0]   imm_z, imm_s, addend;
  logic               is_sub;
  logic [WIDTH:0]     sum_w, shl_w, shr_w, sar_w;
  logic [2*WIDTH-1:0] rol_w;
  logic [WIDTH-1:0]   res_c;
  logic               c_c, v_c, upd_c, wr_c;

  assign amt   = src_b[SH_W-1:0];
  assign imm_z = {{(WIDTH-IMM_W){1'b0}}, imm};
  assign imm_s = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};

  assign is_sub = (op == OP_SUB);
  assign addend = is_sub ? ~src_b : (op == OP_ADDI ? imm_s : src_b);
  assign sum_w  = {1'b0, src_a} + {1'b0, addend} + {{WIDTH{1'b0}}, is_sub};

  assign shl_w = {1'b0, src_a} << amt;
  assign shr_w = {src_a, 1'b0} >> amt;
  assign sar_w = $signed({src_a, 1'b0}) >>> amt;
  assign rol_w = {src_a, src_a} << amt;

  always_comb begin
    res_c = '0;
    c_c   = 1'b0;
    v_c   = 1'b0;
    upd_c = 1'b1;
    wr_c  = 1'b1;
    case (op)
      OP_SHL: begin
        res_c = shl_w[MSB:0];
        c_c   = shl_w[WIDTH];
      end
      OP_ROL: begin
        res_c = rol_w[2*WIDTH-1:WIDTH];
        c_c   = (amt != '0) && rol_w[WIDTH];
      end
      OP_SHR: begin
        res_c = shr_w[WIDTH:1];
        c_c   = shr_w[0];
      end
      OP_SAR: begin
        res_c = sar_w[WIDTH:1];
        c_c   = sar_w[0];
      end
      OP_INV:  res_c = ~src_a;
      OP_AND:  res_c = src_a & src_b;
      OP_OR:   res_c = src_a | src_b;
      OP_XOR:  res_c = src_a ^ src_b;
      OP_ANDI: res_c = src_a & imm_z;
      OP_ADD, OP_SUB, OP_ADDI: begin
        res_c = sum_w[MSB:0];
        c_c   = sum_w[WIDTH];
        v_c   = (src_a[MSB] == addend[MSB]) && (sum_w[MSB] != src_a[MSB]);
      end
      OP_LDI: begin
        res_c = imm_z;
        upd_c = 1'b0;
      end
      default: begin
        upd_c = 1'b0;
        wr_c  = 1'b0;
      end
    endcase
  end

  assign result   = res_c;
  assign wr_en    = wr_c && (dst_sel != '0);
  assign flag_upd = upd_c;
  assign flag_n   = upd_c && res_c[MSB];
  assign flag_z   = upd_c && (res_c == '0);
  assign flag_c   = upd_c && c_c;
  assign flag_v   = upd_c && v_c;
endmodule

// File: rtl/alu_opdec_chk.sv
module alu_opdec_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 20,
  parameter int SEL_W = 3,
  parameter int OP_W  = 5
) (
  input logic [OP_W-1:0]  op,
  input logic [SEL_W-1:0] dst_sel,
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [IMM_W-1:0] imm,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic             flag_upd,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic [WIDTH-1:0] diff_ref, sum_ref;
  assign diff_ref = src_a - src_b;
  assign sum_ref  = src_a + src_b;

  always_comb begin
    if (dst_sel == '0)
      AST_NO_R0_WRITE: assert (!wr_en); // R8
    if (!flag_upd)
      AST_QUIET_FLAGS: assert (!flag_n && !flag_z && !flag_c && !flag_v); // R7
    if (op >= 5'b10000 && op <= 5'b10100)
      AST_SHIFT_NO_OVF: assert (!flag_v); // R1
    if (op == 5'b10101)
      AST_ADD_SUM: assert (result == sum_ref && flag_upd); // R3
    if (op == 5'b10110)
      AST_SUB_BORROW: assert (result == diff_ref && flag_c == (src_a >= src_b)); // R4
    if (op == 5'b00001)
      AST_LDI_NO_FLAGS: assert (!flag_upd && result == WIDTH'(imm)); // R5
    if (op == 5'b00000 || (op >= 5'b00100 && op <= 5'b01111) || op >= 5'b11010)
      AST_IDLE_OP: assert (!wr_en && !flag_upd && result == '0); // R7
  end
endmodule

bind alu_opdec alu_opdec_chk #(
  .WIDTH(WIDTH), .IMM_W(IMM_W), .SEL_W(SEL_W), .OP_W(OP_W)
) u_chk (
  .op(op), .dst_sel(dst_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
  .result(result), .wr_en(wr_en), .flag_upd(flag_upd),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu_opdec_bench.sv
module alu_opdec_bench;
  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  op;
    logic [2:0]  dst;
    logic [31:0] a;
    logic [31:0] b;
    logic [19:0] imm;
    logic [31:0] res;
    logic        we;
    logic        upd;
    logic [3:0]  nzcv;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{8'd1, 5'b10000, 3'd1, 32'h8000_0001, 32'd1,  20'h0, 32'h0000_0002, 1'b1, 1'b1, 4'b0010}, // R1
    '{8'd1, 5'b10000, 3'd1, 32'h0000_0001, 32'd0,  20'h0, 32'h0000_0001, 1'b1, 1'b1, 4'b0000}, // R1
    '{8'd1, 5'b10000, 3'd2, 32'h0000_0001, 32'd31, 20'h0, 32'h8000_0000, 1'b1, 1'b1, 4'b1000}, // R1
    '{8'd1, 5'b10001, 3'd1, 32'h8000_0001, 32'd1,  20'h0, 32'h0000_0003, 1'b1, 1'b1, 4'b0010}, // R1
    '{8'd1, 5'b10010, 3'd1, 32'h8000_0003, 32'd1,  20'h0, 32'h4000_0001, 1'b1, 1'b1, 4'b0010}, // R1
    '{8'd1, 5'b10010, 3'd3, 32'h8000_0003, 32'h20, 20'h0, 32'h8000_0003, 1'b1, 1'b1, 4'b1000}, // R1
    '{8'd1, 5'b10011, 3'd1, 32'h8000_0000, 32'd31, 20'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b1000}, // R1
    '{8'd1, 5'b10011, 3'd4, 32'hF000_0018, 32'h24, 20'h0, 32'hFF00_0001, 1'b1, 1'b1, 4'b1010}, // R1
    '{8'd2, 5'b10100, 3'd1, 32'hFFFF_FFFF, 32'd0,  20'h0, 32'h0000_0000, 1'b1, 1'b1, 4'b0100}, // R2
    '{8'd2, 5'b10111, 3'd5, 32'hF0F0_F0F0, 32'hFF00_FF00, 20'h0, 32'hF000_F000, 1'b1, 1'b1, 4'b1000}, // R2
    '{8'd2, 5'b11000, 3'd1, 32'h0000_00F0, 32'h0000_000F, 20'h0, 32'h0000_00FF, 1'b1, 1'b1, 4'b0000}, // R2
    '{8'd2, 5'b11001, 3'd6, 32'h1234_5678, 32'h1234_5678, 20'h0, 32'h0000_0000, 1'b1, 1'b1, 4'b0100}, // R2
    '{8'd3, 5'b10101, 3'd1, 32'h7FFF_FFFF, 32'd1,  20'h0, 32'h8000_0000, 1'b1, 1'b1, 4'b1001}, // R3
    '{8'd3, 5'b10101, 3'd7, 32'hFFFF_FFFF, 32'd1,  20'h0, 32'h0000_0000, 1'b1, 1'b1, 4'b0110}, // R3
    '{8'd4, 5'b10110, 3'd1, 32'd5,         32'd5,  20'h0, 32'h0000_0000, 1'b1, 1'b1, 4'b0110}, // R4
    '{8'd4, 5'b10110, 3'd1, 32'd3,         32'd5,  20'h0, 32'hFFFF_FFFE, 1'b1, 1'b1, 4'b1000}, // R4
    '{8'd4, 5'b10110, 3'd2, 32'h8000_0000, 32'd1,  20'h0, 32'h7FFF_FFFF, 1'b1, 1'b1, 4'b0011}, // R4
    '{8'd5, 5'b00010, 3'd1, 32'hFFFF_FFFF, 32'd0,  20'hFFFFF, 32'h000F_FFFF, 1'b1, 1'b1, 4'b0000}, // R5
    '{8'd5, 5'b00011, 3'd1, 32'h0000_0010, 32'd0,  20'hFFFFF, 32'h0000_000F, 1'b1, 1'b1, 4'b0010}, // R5
    '{8'd5, 5'b00001, 3'd1, 32'h1234_0000, 32'd0,  20'h80000, 32'h0008_0000, 1'b1, 1'b0, 4'b0000}, // R5
    '{8'd7, 5'b00101, 3'd1, 32'hFFFF_FFFF, 32'd1,  20'h1, 32'h0000_0000, 1'b0, 1'b0, 4'b0000}, // R7
    '{8'd7, 5'b01100, 3'd1, 32'h0000_0000, 32'd0,  20'h0, 32'h0000_0000, 1'b0, 1'b0, 4'b0000}, // R7
    '{8'd7, 5'b11111, 3'd1, 32'h8000_0000, 32'd3,  20'h3, 32'h0000_0000, 1'b0, 1'b0, 4'b0000}, // R7
    '{8'd8, 5'b10101, 3'd0, 32'h0000_0001, 32'hFFFF_FFFF, 20'h0, 32'h0000_0000, 1'b0, 1'b1, 4'b0110}  // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  op = '0;
  logic [2:0]  dst_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [19:0] imm = '0;
  logic [31:0] result;
  logic        wr_en, flag_upd, flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  alu_opdec u_alu_opdec (
    .op(op), .dst_sel(dst_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .wr_en(wr_en), .flag_upd(flag_upd),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic apply_check(input vec_t v);
    logic [37:0] got, exp;
    @(negedge clk);
    op = v.op; dst_sel = v.dst; src_a = v.a; src_b = v.b; imm = v.imm;
    #2;
    got = {result, wr_en, flag_upd, flag_n, flag_z, flag_c, flag_v};
    exp = {v.res, v.we, v.upd, v.nzcv};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d op=%b: actual res=%h we=%b upd=%b nzcv=%b, expected res=%h we=%b upd=%b nzcv=%b",
               v.req, v.op, got[37:6], got[5], got[4], got[3:0],
               v.res, v.we, v.upd, v.nzcv);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset state, R7: halt opcode with all inputs zero
    apply_check('{8'd7, 5'b00000, 3'd0, 32'd0, 32'd0, 20'h0, 32'd0, 1'b0, 1'b0, 4'b0000});
    for (int i = 0; i < NV; i++) apply_check(VEC[i]);
    // R6: negative and zero through add with a fresh destination
    apply_check('{8'd6, 5'b10101, 3'd3, 32'hFFFF_FFF0, 32'd1, 20'h0, 32'hFFFF_FFF1, 1'b1, 1'b1, 4'b1000});
    // R8: subtract at register 0 still reports flags
    apply_check('{8'd8, 5'b10110, 3'd0, 32'd3, 32'd5, 20'h0, 32'hFFFF_FFFE, 1'b0, 1'b1, 4'b1000});
    // R1: rotate by zero leaves operand and clears carry
    apply_check('{8'd1, 5'b10001, 3'd1, 32'h8000_0001, 32'h40, 20'h0, 32'h8000_0001, 1'b1, 1'b1, 4'b1000});
    // R5: ADDI with positive immediate, no carry
    apply_check('{8'd5, 5'b00011, 3'd2, 32'h7FFF_FFFF, 32'd0, 20'h00001, 32'h8000_0000, 1'b1, 1'b1, 4'b1001});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule